// File: doc/BRIEF.md
# Power Mode Supervisor Controller

This block decides which of three operating modes a battery-powered hearing device is in: a low-power sleep mode, a docked charging mode and an active mode in which a host processor is powered. It watches a push-button input, a dock-present signal, a sleep-request pin driven by the host, a set of battery threshold comparator outputs and a few configuration bits. From these it drives the host supply enable, the choice of supply path, a shutdown-warning pin, a safe-mode status bit and a mode code.

All timing is done in clock cycles of the supervisor clock. The button must be held for a qualified number of consecutive samples before the device wakes. The host's sleep request passes through a deglitch filter of its own. When the device is docked while active, the warning pin rises at once and the host supply is removed only after a programmable number of half-second ticks. This gives the host time to shut down cleanly. Comparators, oscillators and power switches are outside the block and appear only as ports.

Top module: `pms_ctrl`

## Requirements
- R1: After reset the mode code is 0 (sleep), the supply enable is 0, the supply path is 0 (off), the warning is 0, the button mirror is 0 and the safe-mode bit is 1.
- R2: A dock-present value of 1 at a clock edge in sleep (mode 0) or active (mode 2) mode moves the mode to docked (mode 1) at that edge. Entering docked mode sets the safe-mode bit to 1.
- R3: The warning output equals the dock-present input in every mode, with no clock delay.
- R4: Sleep goes to active only at the edge after the button input was sampled high on BTN_HOLD_CYCLES consecutive edges. Any low sample restarts the count. The wake also needs the battery window valid and the dock absent.
- R5: Comparator bits are bit0 above 1.0 V, bit1 above 1.1 V, bit2 above 1.5 V, bit3 above 2.2 V and bit4 above 3.0 V. The wake window is valid when (bit1 and not bit3) or bit4.
- R6: In docked mode, a dock-present value of 0 at an edge moves to active if the no-button bit is 1 and the wake window is valid. Otherwise it moves to sleep.
- R7: In active mode, a sleep request sampled high on SLP_HOLD_CYCLES consecutive edges moves to sleep at the following edge, and any low sample restarts the count. The request has no effect in docked or sleep mode, and its count stays at zero there.
- R8: In active mode the battery floor (not bit0, or bit3 and not bit4) moves to sleep at the next edge and clears the safe-mode bit.
- R9: When docked mode is entered with the supply on, the supply stays on for max(D,1) × HALF_SEC_CYCLES edges, where D is the 8-bit delay setting, and then turns off. Entering docked mode from sleep leaves the supply off.
- R10: The button mirror output equals the button input in active mode and is 0 in the other modes.
- R11: While the supply is on, the path code is 3 (divide-by-three) if bit4 is set. It is 2 (1.5 V limiter) if bit2 is set, bit3 is clear and the limiter enable is 1. In all other cases it is 1 (direct switch). The path code is 0 whenever the supply is off. Active mode always has the supply on.
- R12: In active mode, dock-present takes priority over the battery floor, and the battery floor takes priority over a qualified sleep request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| button_i | input | 1 | Push-button level |
| dock_i | input | 1 | Dock present |
| sleep_req_i | input | 1 | Host sleep request |
| cmp_i | input | 5 | Battery threshold comparators (bit0 1.0 V to bit4 3.0 V) |
| cfg_no_button_i | input | 1 | Wake directly when undocked |
| cfg_limiter_en_i | input | 1 | Allow the 1.5 V limiter path |
| cfg_warn_delay_i | input | 8 | Supply-off delay in half-second ticks |
| supply_en_o | output | 1 | Host supply enable |
| supply_path_o | output | 2 | Supply path code |
| warn_o | output | 1 | Shutdown warning |
| safe_mode_o | output | 1 | Safe-mode status |
| button_o | output | 1 | Button mirror for the host |
| mode_o | output | 2 | Mode code |

## Verification
Two events can land on the same edge in active mode. One is the sleep-request filter reaching its qualified count. The other is the dock being connected, or the battery falling to its floor. The bench holds the sleep request for exactly the qualifying number of samples and raises dock-present, or drops the comparators to the floor, on that same edge. It then expects docked mode with the supply still on, or sleep with safe-mode cleared. A cycle model in the bench applies the same priority to long random runs, so these collisions also occur without being set up.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'd0,
        MODE_DOCK   = 2'd1,
        MODE_ACTIVE = 2'd2
    } pm_mode_e;

    typedef enum logic [1:0] {
        PATH_OFF    = 2'd0,
        PATH_DIRECT = 2'd1,
        PATH_LIMIT  = 2'd2,
        PATH_DIV3   = 2'd3
    } path_e;

    localparam int CMP_W    = 5;
    localparam int CMP_1V0  = 0;
    localparam int CMP_1V1  = 1;
    localparam int CMP_1V5  = 2;
    localparam int CMP_2V2  = 3;
    localparam int CMP_3V0  = 4;

    typedef struct packed {
        pm_mode_e mode;
        logic     supply;
        path_e    path;
        logic     safe;
    } ctl_state_t;

endpackage

// File: rtl/pms_hold_filter.sv
module pms_hold_filter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic in_i,
    output logic held_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        held_o = (cnt_q == CNT_W'(LIMIT));
        if (en_i && in_i) begin
            cnt_d = held_o ? cnt_q : cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4 / R7: count never passes the limit
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT));

    // R7: a low or disabled sample always clears qualification
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || !in_i) |=> !held_o);

endmodule

// File: rtl/pms_batt_judge.sv
module pms_batt_judge
    import pms_pkg::*;
(
    input  logic [CMP_W-1:0] cmp_i,
    input  logic             limiter_en_i,
    output logic             wake_ok_o,
    output logic             floor_o,
    output path_e            path_o
);
    logic zinc_band;
    logic lith_band;
    logic mid_gap;

    always_comb begin
        zinc_band = cmp_i[CMP_1V1] && !cmp_i[CMP_2V2];
        lith_band = cmp_i[CMP_3V0];
        mid_gap   = cmp_i[CMP_2V2] && !cmp_i[CMP_3V0];
        wake_ok_o = zinc_band || lith_band;
        floor_o   = !cmp_i[CMP_1V0] || mid_gap;
        if (lith_band) begin
            path_o = PATH_DIV3;
        end else if (cmp_i[CMP_1V5] && !cmp_i[CMP_2V2] && limiter_en_i) begin
            path_o = PATH_LIMIT;
        end else begin
            path_o = PATH_DIRECT;
        end
    end

endmodule

// File: rtl/pms_warn_timer.sv
module pms_warn_timer #(
    parameter int HALF_SEC_CYCLES = 64000,
    parameter int DELAY_W         = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               expire_o
);
    localparam int PRE_W = (HALF_SEC_CYCLES > 1) ? $clog2(HALF_SEC_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(HALF_SEC_CYCLES - 1);

    logic [PRE_W-1:0]   pre_d, pre_q;
    logic [DELAY_W-1:0] tick_d, tick_q;
    logic [DELAY_W-1:0] target;
    logic               pre_wrap;

    always_comb begin
        target   = (delay_i == '0) ? DELAY_W'(1) : delay_i;
        pre_wrap = (pre_q == PRE_LAST);
        expire_o = run_i && pre_wrap && (tick_q == target - 1'b1);
        pre_d    = pre_q;
        tick_d   = tick_q;
        if (!run_i) begin
            pre_d  = '0;
            tick_d = '0;
        end else if (pre_wrap) begin
            pre_d  = '0;
            tick_d = tick_q + 1'b1;
        end else begin
            pre_d  = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else begin
            pre_q  <= pre_d;
            tick_q <= tick_d;
        end
    end

    // R9: prescaler stays inside one half-second period
    a_r9_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);

    // R9: timer is idle whenever it is not running
    a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (tick_q == '0));

endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl
    import pms_pkg::*;
#(
    parameter int BTN_HOLD_CYCLES = 2560,
    parameter int SLP_HOLD_CYCLES = 13,
    parameter int HALF_SEC_CYCLES = 64000,
    parameter int DELAY_W         = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               button_i,
    input  logic               dock_i,
    input  logic               sleep_req_i,
    input  logic [4:0]         cmp_i,
    input  logic               cfg_no_button_i,
    input  logic               cfg_limiter_en_i,
    input  logic [DELAY_W-1:0] cfg_warn_delay_i,
    output logic               supply_en_o,
    output logic [1:0]         supply_path_o,
    output logic               warn_o,
    output logic               safe_mode_o,
    output logic               button_o,
    output logic [1:0]         mode_o
);
    ctl_state_t st_d, st_q;

    logic  btn_held;
    logic  slp_held;
    logic  wake_ok;
    logic  floor_hit;
    logic  expire;
    logic  timer_run;
    path_e path_sel;

    pms_hold_filter #(.LIMIT(BTN_HOLD_CYCLES)) u_btn_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st_q.mode == MODE_SLEEP),
        .in_i   (button_i),
        .held_o (btn_held)
    );

    pms_hold_filter #(.LIMIT(SLP_HOLD_CYCLES)) u_slp_deglitch (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st_q.mode == MODE_ACTIVE),
        .in_i   (sleep_req_i),
        .held_o (slp_held)
    );

    pms_batt_judge u_judge (
        .cmp_i        (cmp_i),
        .limiter_en_i (cfg_limiter_en_i),
        .wake_ok_o    (wake_ok),
        .floor_o      (floor_hit),
        .path_o       (path_sel)
    );

    assign timer_run = (st_q.mode == MODE_DOCK) && st_q.supply;

    pms_warn_timer #(
        .HALF_SEC_CYCLES (HALF_SEC_CYCLES),
        .DELAY_W         (DELAY_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (timer_run),
        .delay_i  (cfg_warn_delay_i),
        .expire_o (expire)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_SLEEP: begin
                if (dock_i) begin
                    st_d.mode = MODE_DOCK;
                end else if (btn_held && wake_ok) begin
                    st_d.mode = MODE_ACTIVE;
                end
            end
            MODE_DOCK: begin
                if (!dock_i) begin
                    st_d.mode = (cfg_no_button_i && wake_ok) ? MODE_ACTIVE : MODE_SLEEP;
                end
            end
            MODE_ACTIVE: begin
                if (dock_i) begin
                    st_d.mode = MODE_DOCK;
                end else if (floor_hit) begin
                    st_d.mode = MODE_SLEEP;
                    st_d.safe = 1'b0;
                end else if (slp_held) begin
                    st_d.mode = MODE_SLEEP;
                end
            end
            default: st_d.mode = MODE_SLEEP;
        endcase

        unique case (st_d.mode)
            MODE_ACTIVE: st_d.supply = 1'b1;
            MODE_DOCK:   st_d.supply = (st_q.mode == MODE_DOCK) ?
                                       (st_q.supply && !expire) : st_q.supply;
            default:     st_d.supply = 1'b0;
        endcase

        if ((st_d.mode == MODE_DOCK) && (st_q.mode != MODE_DOCK)) begin
            st_d.safe = 1'b1;
        end

        st_d.path = st_d.supply ? path_sel : PATH_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_SLEEP;
            st_q.supply <= 1'b0;
            st_q.path   <= PATH_OFF;
            st_q.safe   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign supply_en_o   = st_q.supply;
    assign supply_path_o = st_q.path;
    assign warn_o        = dock_i;
    assign safe_mode_o   = st_q.safe;
    assign button_o      = (st_q.mode == MODE_ACTIVE) && button_i;
    assign mode_o        = st_q.mode;

    // R2: dock presence always lands in docked mode
    a_r2_dock_enters: assert property (@(posedge clk) disable iff (!rst_n)
        dock_i |=> (st_q.mode == MODE_DOCK));

    // R1 / R11: sleep mode never powers the host
    a_r11_sleep_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SLEEP) |-> (!st_q.supply && st_q.path == PATH_OFF));

    // R11: active mode always has a live path
    a_r11_active_powered: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ACTIVE) |-> (st_q.supply && st_q.path != PATH_OFF));

    // R8: safe-mode only falls on a drop from active to sleep
    a_r8_safe_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.safe) |-> (st_q.mode == MODE_SLEEP && $past(st_q.mode) == MODE_ACTIVE));

    // R4: no wake without a qualified button and a valid window
    a_r4_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SLEEP && !(btn_held && wake_ok)) |=> (st_q.mode != MODE_ACTIVE));

    // R9: supply in docked mode only drops when the timer expires
    a_r9_hold_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_DOCK && st_q.supply && dock_i && !expire) |=> st_q.supply);

    // R7: active mode is kept when nothing asks to leave
    a_r7_stay_active: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ACTIVE && !dock_i && !floor_hit && !slp_held)
        |=> (st_q.mode == MODE_ACTIVE));

endmodule

// File: tb/pms_ctrl_tb_top.sv
module pms_ctrl_tb_top;
    localparam int BH = 5;
    localparam int SH = 4;
    localparam int HH = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       button;
    logic       dock;
    logic       sleep_req;
    logic [4:0] cmp;
    logic       no_btn;
    logic       lim_en;
    logic [7:0] delay;
    logic       supply_en;
    logic [1:0] path;
    logic       warn;
    logic       safe;
    logic       btn_out;
    logic [1:0] mode;

    always #4 clk = ~clk;

    pms_ctrl #(
        .BTN_HOLD_CYCLES (BH),
        .SLP_HOLD_CYCLES (SH),
        .HALF_SEC_CYCLES (HH),
        .DELAY_W         (8)
    ) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .button_i         (button),
        .dock_i           (dock),
        .sleep_req_i      (sleep_req),
        .cmp_i            (cmp),
        .cfg_no_button_i  (no_btn),
        .cfg_limiter_en_i (lim_en),
        .cfg_warn_delay_i (delay),
        .supply_en_o      (supply_en),
        .supply_path_o    (path),
        .warn_o           (warn),
        .safe_mode_o      (safe),
        .button_o         (btn_out),
        .mode_o           (mode)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int cyc    = 0;

    int m_mode, m_sup, m_path, m_safe, m_bc, m_sc, m_cc;

    function automatic logic [4:0] lvl(int l);
        logic [5:0] t;
        t = (6'd1 << l) - 6'd1;
        return t[4:0];
    endfunction

    function automatic int f_valid(logic [4:0] c);
        return ((c[1] && !c[3]) || c[4]) ? 1 : 0;
    endfunction

    function automatic int f_floor(logic [4:0] c);
        return (!c[0] || (c[3] && !c[4])) ? 1 : 0;
    endfunction

    function automatic int f_path(logic [4:0] c, logic le);
        if (c[4]) return 3;
        if (c[2] && !c[3] && le) return 2;
        return 1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_sup = 0; m_path = 0; m_safe = 1;
        m_bc = 0; m_sc = 0; m_cc = 0;
    endtask

    task automatic step();
        int nm, ns, nsafe, tgt, exp_now, bh, sh;
        #1;
        chk("R2 R4 R6 R7 R8 R12 mode", int'(mode), m_mode);
        chk("R9 supply", int'(supply_en), m_sup);
        chk("R11 path", int'(path), m_path);
        chk("R3 warn", int'(warn), int'(dock));
        chk("R2 R8 safe", int'(safe), m_safe);
        chk("R10 button", int'(btn_out), (m_mode == 2 && button) ? 1 : 0);
        bh = (m_bc == BH) ? 1 : 0;
        sh = (m_sc == SH) ? 1 : 0;
        tgt = (delay == 0) ? 1 : int'(delay);
        exp_now = (m_mode == 1 && m_sup == 1 && m_cc == tgt * HH - 1) ? 1 : 0;
        nm = m_mode;
        nsafe = m_safe;
        case (m_mode)
            0: if (dock) nm = 1; else if (bh && f_valid(cmp)) nm = 2;
            1: if (!dock) nm = (no_btn && f_valid(cmp)) ? 2 : 0;
            default: begin
                if (dock) nm = 1;
                else if (f_floor(cmp)) begin nm = 0; nsafe = 0; end
                else if (sh) nm = 0;
            end
        endcase
        if (nm == 2) ns = 1;
        else if (nm == 0) ns = 0;
        else if (m_mode == 1) ns = (m_sup && !exp_now) ? 1 : 0;
        else ns = m_sup;
        if (nm == 1 && m_mode != 1) nsafe = 1;
        m_bc = (m_mode == 0 && button) ? ((m_bc == BH) ? BH : m_bc + 1) : 0;
        m_sc = (m_mode == 2 && sleep_req) ? ((m_sc == SH) ? SH : m_sc + 1) : 0;
        m_cc = (m_mode == 1 && m_sup == 1) ? m_cc + 1 : 0;
        m_path = ns ? f_path(cmp, lim_en) : 0;
        m_mode = nm;
        m_sup = ns;
        m_safe = nsafe;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        rst_n = 0; button = 0; dock = 0; sleep_req = 0;
        cmp = lvl(3); no_btn = 0; lim_en = 1; delay = 8'd3;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset supply", int'(supply_en), 0);
        chk("R1 reset path", int'(path), 0);
        chk("R1 reset warn", int'(warn), 0);
        chk("R1 reset safe", int'(safe), 1);
        chk("R1 reset button", int'(btn_out), 0);
        @(negedge clk);
        rst_n = 1;
        model_reset();

        // R4: one sample short of the hold does not wake
        button = 1; run(BH - 1); button = 0; run(2);
        chk("R4 short hold", int'(mode), 0);
        // R4: full hold wakes one edge later, limiter path
        button = 1; run(BH);
        chk("R4 not yet", int'(mode), 0);
        run(1);
        chk("R4 woke", int'(mode), 2);
        chk("R11 limiter", int'(path), 2);
        chk("R10 mirror high", int'(btn_out), 1);
        button = 0; run(1);
        // R7: deglitched sleep request
        sleep_req = 1; run(SH);
        chk("R7 not yet", int'(mode), 2);
        run(1);
        chk("R7 slept", int'(mode), 0);
        sleep_req = 0; run(1);
        // R4: glitch restarts hold count
        button = 1; run(3); button = 0; run(1); button = 1; run(3); button = 0; run(1);
        chk("R4 glitch", int'(mode), 0);
        // R5: gap between 2.2 V and 3.0 V is not a wake window
        cmp = lvl(4); button = 1; run(BH + 3);
        chk("R5 invalid window", int'(mode), 0);
        cmp = lvl(1); run(BH + 3);
        chk("R5 below 1.1", int'(mode), 0);
        cmp = lvl(5); run(2);
        chk("R5 lithium wake", int'(mode), 2);
        chk("R11 div3", int'(path), 3);
        button = 0; run(2);
        // R8: floor in active drops to sleep and clears safe mode
        cmp = lvl(4); run(1);
        chk("R8 floor", int'(mode), 0);
        chk("R8 safe cleared", int'(safe), 0);
        cmp = lvl(2); button = 1; run(BH + 1); button = 0;
        chk("R11 direct", int'(path), 1);
        lim_en = 0; cmp = lvl(3); run(1);
        chk("R11 limiter off", int'(path), 1);
        lim_en = 1; run(1);
        // R2 R3 R9: dock in active, delay 3 ticks
        dock = 1; #1;
        chk("R3 warn at once", int'(warn), 1);
        run(1);
        chk("R2 docked", int'(mode), 1);
        chk("R2 safe set", int'(safe), 1);
        sleep_req = 1;
        run(3 * HH - 1);
        chk("R9 still on", int'(supply_en), 1);
        run(1);
        chk("R9 cut", int'(supply_en), 0);
        run(20);
        chk("R7 ignored docked", int'(mode), 1);
        sleep_req = 0;
        // R6: undock without no-button goes to sleep
        dock = 0; run(1);
        chk("R6 to sleep", int'(mode), 0);
        dock = 1; run(1);
        chk("R9 from sleep off", int'(supply_en), 0);
        no_btn = 1; dock = 0; run(1);
        chk("R6 to active", int'(mode), 2);
        // R9: delay code 0 acts as one tick
        delay = 0; dock = 1; run(1);
        run(HH - 1);
        chk("R9 zero still on", int'(supply_en), 1);
        run(1);
        chk("R9 zero cut", int'(supply_en), 0);
        dock = 0; run(1);
        // R12: dock and qualified sleep on the same edge
        sleep_req = 1; run(SH); dock = 1; run(1);
        chk("R12 dock wins", int'(mode), 1);
        chk("R12 supply kept", int'(supply_en), 1);
        sleep_req = 0; dock = 0; run(1);
        // R12: floor and qualified sleep on the same edge
        sleep_req = 1; run(SH); cmp = lvl(0); run(1);
        chk("R12 floor wins", int'(safe), 0);
        sleep_req = 0; cmp = lvl(3); run(2);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 60 == 0) dock = ~dock;
            if ($urandom % 5 == 0) button = $urandom % 2;
            if ($urandom % 6 == 0) sleep_req = $urandom % 2;
            if ($urandom % 30 == 0) cmp = lvl($urandom % 6);
            if ($urandom % 50 == 0) begin
                lim_en = $urandom % 2;
                no_btn = $urandom % 2;
            end
            if (!dock && m_mode != 1 && $urandom % 40 == 0) delay = 8'($urandom % 5);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule